// File: doc/BRIEF.md
# Handshake Averaging Filter Controller

This block is a streaming two-tap averaging filter. It accepts one sample per transaction on an input channel and emits, on an output channel, the mean of that sample and the sample accepted before it. Both channels use a four-phase request/acknowledge protocol with bundled data. The first sample after reset is averaged against zero.

Inside, a clocked sequencer drives four channels in a fixed order: an input capture stage, a history stage, an adder stage and the output channel. Each internal stage answers its request with an acknowledge after a fixed number of cycles. The adder's completion is modelled as a matched delay counted in clock cycles. The history stage loads the current sample only on the return-to-zero half of its handshake. That happens after the output has been latched, so every average uses the previous sample.

The sum is formed one bit wider than the samples, and the mean is the upper bits of that sum. The environment may change the input data as soon as the input acknowledge rises.

Top module: `hsf_avg_filter`

## Requirements
- R1: After reset, in_ack, out_req and out_data are 0 and the stored history is 0, so the first output equals the first sample shifted right by one.
- R2: Each output equals (sample + history) >> 1, with the sum taken DATA_W+1 bits wide so that no carry is lost (255 and 255 give 255 at DATA_W = 8).
- R3: After each transaction the history holds that transaction's sample and is used by the next one.
- R4: in_ack rises on the 2nd rising clock edge after in_req is first seen high in idle, counting that edge as the 1st. in_data is captured on the edge where in_ack rises, and changes to in_data after that have no effect on the result.
- R5: Internal requests rise in the order capture, history, adder, output. Each one rises only after the previous stage has acknowledged.
- R6: The adder acknowledges ADD_DELAY cycles after its request. out_req rises on the (ADD_DELAY+6)-th rising edge after in_req is first seen high in idle, counting that edge as the 1st.
- R7: The return-to-zero starts only when in_req is low and out_ack is high, and requests fall in the same order as they rose. While out_ack stays low, out_req and in_ack both stay high. in_ack falls before out_req falls.
- R8: out_data is stable while out_req is high, and it holds its value after out_req falls until the next out_req rise.
- R9: A new transaction is not accepted until out_ack has returned low: with out_ack still high, a raised in_req gets no in_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_req | input | 1 | Input request: in_data is valid |
| in_ack | output | 1 | Input acknowledge: sample captured |
| in_data | input | DATA_W | Input sample |
| out_req | output | 1 | Output request: out_data is valid |
| out_ack | input | 1 | Output acknowledge from the consumer |
| out_data | output | DATA_W | Averaged result |

## Verification
A table of samples walks the history through three kinds of case. Small ascending values show that the previous sample, not the current one, is averaged in. Runs of 255 show that the extra carry bit is kept. Odd sums such as 0+1 show that the shift truncates. Each transaction also scrambles in_data once in_ack rises, which separates capture on the acknowledge edge from a transparent path. Directed runs stall out_ack, hold out_ack high across a new request, and reset mid-stream, which tells apart correct release ordering, a premature restart and a history that survives reset.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_XUP,
    ST_YUP,
    ST_AUP,
    ST_OUT,
    ST_XDN,
    ST_YDN,
    ST_ADN,
    ST_ODN
  } seq_e;
endpackage

// File: rtl/hsf_stage.sv
module hsf_stage #(
  parameter int W            = 8,
  parameter int LAT          = 1,
  parameter bit LOAD_ON_FALL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] d,
  output logic         ack,
  output logic [W-1:0] q
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_d;
  logic          busy, done, load;

  assign busy = req ^ ack;
  assign done = busy && (cnt_q == LAST);

  generate
    if (LOAD_ON_FALL) begin : g_fall
      assign load = done && !req;
      // history only changes on the return-to-zero half
      assert_hist_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> !$past(req));
    end else begin : g_rise
      assign load = done && req;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    ack_d = ack;
    if (!busy) begin
      cnt_d = '0;
    end else if (done) begin
      cnt_d = '0;
      ack_d = req;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ack   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ack   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

  // acknowledge only ever copies the request it answered
  assert_ack_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack) |-> (ack == $past(req)));
endmodule

// File: rtl/hsf_ctrl.sv
module hsf_ctrl
  import hsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic out_ack,
  input  logic ax,
  input  logic ay,
  input  logic aa,
  output logic rx,
  output logic ry,
  output logic ra,
  output logic rout,
  output logic out_load
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (in_req)              st_d = ST_XUP;
      ST_XUP:  if (ax)                  st_d = ST_YUP;
      ST_YUP:  if (ay)                  st_d = ST_AUP;
      ST_AUP:  if (aa)                  st_d = ST_OUT;
      ST_OUT:  if (out_ack && !in_req)  st_d = ST_XDN;
      ST_XDN:  if (!ax)                 st_d = ST_YDN;
      ST_YDN:  if (!ay)                 st_d = ST_ADN;
      ST_ADN:  if (!aa)                 st_d = ST_ODN;
      ST_ODN:  if (!out_ack)            st_d = ST_IDLE;
      default:                          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rx   <= 1'b0;
      ry   <= 1'b0;
      ra   <= 1'b0;
      rout <= 1'b0;
    end else begin
      st_q <= st_d;
      rx   <= (st_d inside {ST_XUP, ST_YUP, ST_AUP, ST_OUT});
      ry   <= (st_d inside {ST_YUP, ST_AUP, ST_OUT, ST_XDN});
      ra   <= (st_d inside {ST_AUP, ST_OUT, ST_XDN, ST_YDN});
      rout <= (st_d inside {ST_OUT, ST_XDN, ST_YDN, ST_ADN});
    end
  end

  assign out_load = (st_q == ST_AUP) && aa;

  assert_rise_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ry) |-> $past(rx && ax));
  assert_rise_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ra) |-> $past(ry && ay));
  assert_rise_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rout) |-> $past(ra && aa));
  assert_fall_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx) |-> $past(!in_req && out_ack));
  assert_fall_y_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ry) |-> $past(!rx && !ax));
  assert_fall_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ra) |-> $past(!ry && !ay));
  assert_fall_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rout) |-> $past(!ra && !aa));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx) |-> $past(!out_ack));
endmodule

// File: rtl/hsf_avg_filter.sv
module hsf_avg_filter #(
  parameter int DATA_W    = 8,
  parameter int ADD_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  output logic              in_ack,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_data
);
  localparam int SUM_W = DATA_W + 1;

  logic [1:0]        rst_pipe;
  logic              rst_n_i;
  logic              rx, ry, ra, rout, out_load;
  logic              ax, ay, aa;
  logic [DATA_W-1:0] x_q, y_q, avg_q;
  logic [SUM_W-1:0]  sum_w;
  logic [DATA_W-1:0] avg_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe[1];

  hsf_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .in_req   (in_req),
    .out_ack  (out_ack),
    .ax       (ax),
    .ay       (ay),
    .aa       (aa),
    .rx       (rx),
    .ry       (ry),
    .ra       (ra),
    .rout     (rout),
    .out_load (out_load)
  );

  hsf_stage #(.W(DATA_W), .LAT(1), .LOAD_ON_FALL(1'b0)) u_xstage (
    .clk (clk), .rst_n (rst_n_i), .req (rx), .d (in_data), .ack (ax), .q (x_q)
  );

  hsf_stage #(.W(DATA_W), .LAT(1), .LOAD_ON_FALL(1'b1)) u_ystage (
    .clk (clk), .rst_n (rst_n_i), .req (ry), .d (x_q), .ack (ay), .q (y_q)
  );

  assign sum_w = {1'b0, x_q} + {1'b0, y_q};
  assign avg_w = sum_w[SUM_W-1:1];

  hsf_stage #(.W(DATA_W), .LAT(ADD_DELAY), .LOAD_ON_FALL(1'b0)) u_astage (
    .clk (clk), .rst_n (rst_n_i), .req (ra), .d (avg_w), .ack (aa), .q (avg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (!rst_n_i) begin
      out_data <= '0;
    end else if (out_load) begin
      out_data <= avg_q;
    end
  end

  assign in_ack  = ax;
  assign out_req = rout;

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (out_req && $past(out_req)) |-> $stable(out_data));
  assert_out_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!out_req && !$rose(out_req)) |-> $stable(out_data));
  assert_ack_before_out_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(out_req) |-> !in_ack);
endmodule

// File: tb/sim_hsf_avg_filter.sv
`timescale 1ns/1ps
module sim_hsf_avg_filter;
  localparam int DW  = 8;
  localparam int DLY = 2;
  localparam int LATENCY = DLY + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_req = 1'b0;
  logic out_ack = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ack, out_req;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // {sample, expected average}
  localparam logic [15:0] VEC [8] = '{
    {8'd10,  8'd5},   {8'd20,  8'd15},  {8'd255, 8'd137}, {8'd255, 8'd255},
    {8'd0,   8'd127}, {8'd1,   8'd0},   {8'd2,   8'd1},   {8'd200, 8'd101}
  };

  always #2.5 clk = ~clk;

  hsf_avg_filter #(.DATA_W(DW), .ADD_DELAY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic xfer(input logic [DW-1:0] x, input logic [DW-1:0] exp,
                      input int stall, input bit hold_ack);
    int n = 0;
    int nack = 0;
    int m = 0;
    bit ack_low_first = 1'b0;
    @(negedge clk);
    in_data = x;
    in_req  = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (in_ack && nack == 0) begin
        nack    = n;
        in_data = ~x;     // R4: later input changes must not matter
        in_req  = 1'b0;
      end
    end while (!out_req && n < 64);
    chk(nack == 2, "R4 in_ack edge", nack, 2);
    chk(n == LATENCY, "R6 out_req latency", n, LATENCY);
    chk(out_data == exp, "R2 R3 out_data", out_data, exp);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_req && in_ack, "R7 stall holds out_req and in_ack", {out_req, in_ack}, 3);
      chk(out_data == exp, "R8 out_data stable while out_req", out_data, exp);
    end
    out_ack = 1'b1;
    do begin
      @(negedge clk);
      m++;
      if (!in_ack && out_req) ack_low_first = 1'b1;
    end while (out_req && m < 64);
    chk(ack_low_first, "R7 in_ack falls before out_req", ack_low_first, 1);
    chk(out_data == exp, "R8 out_data held after out_req falls", out_data, exp);
    if (!hold_ack) begin
      out_ack = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ack && !out_req && out_data == 0, "R1 reset outputs", {in_ack, out_req, out_data}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!in_ack && !out_req && out_data == 0, "R1 outputs after release", {in_ack, out_req, out_data}, 0);

    // table walk: R1 (first vs zero), R2 (carry), R3 (history)
    for (int i = 0; i < 8; i++) begin
      xfer(VEC[i][15:8], VEC[i][7:0], 0, 1'b0);
    end

    // R7: consumer stalls, out_ack then kept high for R9
    xfer(8'd50, 8'd125, 4, 1'b1);

    // R9: no new acceptance while out_ack is still high
    @(negedge clk);
    in_data = 8'd90;
    in_req  = 1'b1;
    repeat (6) @(negedge clk);
    chk(!in_ack, "R9 no in_ack while out_ack high", in_ack, 0);
    chk(!out_req, "R9 no out_req while out_ack high", out_req, 0);
    in_req  = 1'b0;
    out_ack = 1'b0;
    repeat (3) @(negedge clk);

    xfer(8'd60, 8'd55, 0, 1'b0);   // history 50 -> (50+60)>>1, R3

    // mid-stream reset clears history, R1
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!in_ack && !out_req && out_data == 0, "R1 reset mid-stream", {in_ack, out_req, out_data}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(8'd100, 8'd50, 0, 1'b0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule